// File: doc/BRIEF.md
# eMMC CMD0 Serial Command Decoder

This block watches the single-bit eMMC command line, sampled on each rising edge of the host clock, and recognises the three reset-class command frames that a host issues before it reads boot data. No chip-select frames the traffic. The line rests at logic 1, so the decoder throws away every idle 1 bit. It treats the first 0 bit it sees as the start bit of a 48-bit frame.

It shifts the frame in most significant bit first. When the final bit arrives, the decoder compares the whole frame, CRC byte included, against three fixed patterns. It then reports the result as a one-clock strobe with a 2-bit class code. After each frame it goes straight back to hunting for the next start bit, so frames may follow one another with no idle bits between them. The block does not compute a CRC, because the CRC bytes are part of the fixed patterns.

Top module: `emmc_cmd0_decoder`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `dec_valid` = 0 and `dec_code` = 0, and any partly received frame is discarded.
- R2: Bits of value 1 received while no frame is in progress are discarded and produce no `dec_valid` pulse, however many there are.
- R3: A frame of 0x400000000095 yields `dec_code` = 0 (go-idle). `dec_valid` is high in the clock cycle right after the rising edge that samples the 48th bit.
- R4: A frame of 0x40F0F0F0F0FD yields `dec_code` = 1 (go-pre-idle).
- R5: A frame of 0x40FFFFFFFAE5 yields `dec_code` = 2 (boot-initiation).
- R6: Any other 48-bit frame yields `dec_code` = 3 (error). This covers a known argument with a wrong CRC byte, and a frame whose second bit is 0.
- R7: Each frame gives exactly one `dec_valid` pulse, one cycle long. Two strobes are always at least 48 cycles apart.
- R8: After a frame, the next sampled 0 bit starts a new frame at once, so frames sent back to back with no idle bits are each decoded.
- R9: `dec_code` changes only in a cycle in which `dec_valid` is high, or through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock; the command line is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_in | input | 1 | Serial command line, idles high |
| dec_valid | output | 1 | One-cycle strobe marking a classified frame |
| dec_code | output | 2 | Class of the last frame: 0 idle, 1 pre-idle, 2 boot, 3 error |

## Verification
The three legal frames are each sent after long runs of idle ones and also back to back. This separates correct alignment on the first 0 bit from alignment that depends on idle gaps. Error frames are built to differ from a legal frame in only one place: in the CRC byte, in the argument, or in the transmission bit. A decoder that compares only part of the frame would report one of these as legal. A frame cut off by reset, followed by a complete one, shows whether stale partial bits leak into the next frame.

// File: rtl/emmc_cmd0_decoder.sv
module emmc_cmd0_decoder #(
  parameter int FRAME_BITS = 48,
  parameter logic [FRAME_BITS-1:0] IDLE_FRAME    = 48'h4000_0000_0095,
  parameter logic [FRAME_BITS-1:0] PREIDLE_FRAME = 48'h40F0_F0F0_F0FD,
  parameter logic [FRAME_BITS-1:0] BOOT_FRAME    = 48'h40FF_FFFF_FAE5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_in,
  output logic       dec_valid,
  output logic [1:0] dec_code
);

  localparam int CW = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-2:0] shreg;
  logic [CW-1:0]         cnt;
  logic                  busy;
  logic [1:0]            cls;

  wire [FRAME_BITS-1:0] frame = {shreg, cmd_in};
  wire                  last  = busy && (cnt == CW'(FRAME_BITS - 1));

  always_comb begin
    if (frame == IDLE_FRAME)         cls = 2'd0;
    else if (frame == PREIDLE_FRAME) cls = 2'd1;
    else if (frame == BOOT_FRAME)    cls = 2'd2;
    else                             cls = 2'd3;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      dec_valid <= 1'b0;
      dec_code  <= 2'd0;
    end else begin
      dec_valid <= 1'b0;
      if (busy || !cmd_in)
        shreg <= {shreg[FRAME_BITS-3:0], cmd_in};
      if (!busy) begin
        if (!cmd_in) begin
          busy <= 1'b1;
          cnt  <= CW'(1);
        end
      end else if (last) begin
        busy      <= 1'b0;
        cnt       <= '0;
        dec_valid <= 1'b1;
        dec_code  <= cls;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/emmc_cmd0_decoder_chk.sv
module emmc_cmd0_decoder_chk #(
  parameter int FRAME_BITS = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_in,
  input logic       dec_valid,
  input logic [1:0] dec_code
);

  localparam int GW = $clog2(FRAME_BITS + 1);

  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)
      gap <= '0;
    else if (dec_valid)
      gap <= GW'(1);
    else if (gap != GW'(FRAME_BITS))
      gap <= gap + GW'(1);
  end

  p_reset_clears_r1: assert property (@(posedge clk)
    !rst_n |=> (!dec_valid && dec_code == 2'd0));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  p_min_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (gap == GW'(FRAME_BITS)));

  p_code_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> (dec_valid || $stable(dec_code)));

  p_no_x_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown({dec_valid, dec_code}));

endmodule

bind emmc_cmd0_decoder emmc_cmd0_decoder_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in),
  .dec_valid(dec_valid), .dec_code(dec_code)
);

// File: tb/sim_emmc_cmd0_decoder.sv
module sim_emmc_cmd0_decoder;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_in = 1'b1;
  logic       dec_valid;
  logic [1:0] dec_code;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  bit done = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  emmc_cmd0_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in),
    .dec_valid(dec_valid), .dec_code(dec_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      pulses++;
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected strobe", int'(dec_code), -1);
      end else begin
        automatic logic [1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(dec_code == e, t, int'(dec_code), int'(e));
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); cmd_in = 1'b1; end
  endtask

  task automatic send_frame(input logic [47:0] f, input int lead,
                            input logic [1:0] exp, input string tag);
    idle(lead);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int i = 47; i >= 0; i--) begin
      @(negedge clk);
      cmd_in = f[i];
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk(dec_valid == 1'b0 && dec_code == 2'd0, "R1 reset state", {dec_valid, dec_code}, 0);
    rst_n = 1'b1;

    // R2: long idle run produces nothing
    p0 = pulses;
    idle(200);
    chk(pulses == p0, "R2 idle ones ignored", pulses - p0, 0);

    // R3: go-idle with exact strobe timing
    send_frame(48'h4000_0000_0095, 10, 2'd0, "R3 go-idle code");
    @(negedge clk); cmd_in = 1'b1;
    chk(dec_valid == 1'b1, "R3 strobe one cycle after last bit", dec_valid, 1);
    @(negedge clk);
    chk(dec_valid == 1'b0, "R7 strobe lasts one cycle", dec_valid, 0);

    send_frame(48'h40F0_F0F0_F0FD, 37, 2'd1, "R4 go-pre-idle code");
    send_frame(48'h40FF_FFFF_FAE5, 5, 2'd2, "R5 boot code");

    // R6: near misses
    send_frame(48'h4000_0000_0094, 3, 2'd3, "R6 bad CRC");
    send_frame(48'h40F0_F0F0_F1FD, 3, 2'd3, "R6 bad argument");
    send_frame(48'h00FF_FFFF_FAE5, 3, 2'd3, "R6 transmission bit 0");
    send_frame(48'h7FFF_FFFF_FFFF, 3, 2'd3, "R6 start then all ones");

    // R8: back to back, no idle gap
    send_frame(48'h40FF_FFFF_FAE5, 2, 2'd2, "R8 back-to-back boot");
    send_frame(48'h4000_0000_0095, 0, 2'd0, "R8 back-to-back idle");
    send_frame(48'h40F0_F0F0_F0FD, 0, 2'd1, "R8 back-to-back pre-idle");
    send_frame(48'h4000_0000_0094, 0, 2'd3, "R8 back-to-back error");
    idle(5);

    // R1: reset in mid-frame discards partial bits
    for (int i = 47; i >= 28; i--) begin
      @(negedge clk); cmd_in = 48'h40FF_FFFF_FAE5 >> i;
    end
    @(negedge clk); rst_n = 1'b0; cmd_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(dec_valid == 1'b0 && dec_code == 2'd0, "R1 reset clears mid-frame", {dec_valid, dec_code}, 0);
    rst_n = 1'b1;
    p0 = pulses;
    send_frame(48'h4000_0000_0095, 4, 2'd0, "R1 clean frame after reset");
    idle(60);
    chk(pulses == p0 + 1, "R7 one strobe per frame", pulses - p0, 1);

    // R9: code holds across long idle
    idle(100);
    chk(dec_code == 2'd0, "R9 code held while idle", dec_code, 0);

    chk(exp_q.size() == 0, "R7 all expected strobes seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule